// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads a 64-key switch matrix wired as eight column drive lines and eight row return lines. While no key is down it drives every column at once and, once per sampling period, looks at the row byte. An all-zero byte means the matrix is quiet, so it needs only one comparison per period. A non-zero byte starts a decode pass. In that pass the columns are driven one at a time in ascending order, and each is held for a settling time before its rows are sampled. The first column that returns a non-zero row byte gives the key position.

A key counts as pressed only when the same position comes out of several scans in a row. When that happens the block latches a 6-bit key code, raises a valid flag and an interrupt, and goes back to driving all columns. The host clears the flag and the interrupt with a one-cycle read strobe. Once a key has been reported, the block ignores the matrix until it has seen an all-zero row byte on enough consecutive idle samples, so a key that is held down is reported only once. Row inputs pass through a two-stage synchronizer before any decision is made on them.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, colStrobe is 8'hFF, keyValid and irq are 0, and keyCode is 0.
- R2: While no key is closed, colStrobe stays 8'hFF on every cycle.
- R3: A non-zero row byte seen on an idle sample starts a decode pass. The pass drives exactly one column at a time (column c drives colStrobe[c], active high) in ascending order, starting at column 0. It stops at the first column whose rows are non-zero, or after column 7, and then colStrobe returns to 8'hFF.
- R4: keyCode holds the column index in bits [5:3] and the row index in bits [2:0]. Row r drives rowSense[r], active high. When several rows are set, the lowest-numbered set row is reported.
- R5: A key is accepted only after DEBOUNCE_COUNT consecutive decode passes (default 4) give the same code. A press that is released before that many passes is never reported.
- R6: On acceptance, keyCode is loaded, and keyValid and irq go to 1.
- R7: A one-cycle rdStrobe clears keyValid and irq. keyCode keeps its value until the next acceptance.
- R8: After a key is reported, no further report is made until DEBOUNCE_COUNT consecutive idle samples read 8'h00. A key held down is therefore reported once, and it can be reported again after it is released and pressed anew.
- R9: A decode pass that finds no non-zero column reports nothing, and the block returns to driving all columns.
- R10: Every column in a decode pass stays driven for exactly SETTLE_CYCLES clock cycles (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rowSense | input | 8 | Row return lines, active high, asynchronous to clk |
| rdStrobe | input | 1 | Host read strobe; clears the valid flag and the interrupt |
| colStrobe | output | 8 | Column drive lines, active high |
| keyCode | output | 6 | Accepted key: {column, row} |
| keyValid | output | 1 | An unread key code is present |
| irq | output | 1 | Interrupt request, raised on acceptance |

## Verification
A wrong column counter or settle timer shows up at colStrobe within one settle window as a missing, repeated or lengthened one-hot step, so the bench times every step of a decode pass. A debounce counter that miscounts changes how many column-0 pulses come before keyValid rises, and the bench counts those pulses. A release lock that never clears shows as a missing second report after release, and one that clears too early shows as a repeated report while the key is held. Each of these appears within a few hundred cycles.

// File: rtl/kps_pkg.sv
package kps_pkg;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic driveAll;
    logic loadIdle;
    logic loadSettle;
    logic colReset;
    logic colAdvance;
    logic evalCand;
    logic clearMatch;
    logic sampleZeroIdle;
    logic sampleHitLocked;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic timerDone;
    logic rowsHit;
    logic lastCol;
    logic locked;
  } stat_t;

endpackage

// File: rtl/kps_datapath.sv
module kps_datapath
  import kps_pkg::*;
#(
  parameter int NUM_COLS       = 8,
  parameter int NUM_ROWS       = 8,
  parameter int IDLE_PERIOD    = 16,
  parameter int SETTLE_CYCLES  = 4,
  parameter int DEBOUNCE_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_t               ctrl,
  input  logic [NUM_ROWS-1:0] rowSense,
  input  logic                rdStrobe,
  output stat_t               st,
  output logic [NUM_COLS-1:0] colStrobe,
  output logic [$clog2(NUM_COLS)+$clog2(NUM_ROWS)-1:0] keyCode,
  output logic                keyValid,
  output logic                irq
);
  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int CODE_W = COL_W + ROW_W;
  localparam int MAX_T  = (IDLE_PERIOD > SETTLE_CYCLES) ? IDLE_PERIOD : SETTLE_CYCLES;
  localparam int TMR_W  = $clog2(MAX_T + 1);
  localparam int CNT_W  = $clog2(DEBOUNCE_COUNT + 1);

  // two-stage row synchronizer
  logic [NUM_ROWS-1:0] rowMeta, rowSync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowMeta <= '0;
      rowSync <= '0;
    end else begin
      rowMeta <= rowSense;
      rowSync <= rowMeta;
    end
  end

  // lowest set row
  logic [ROW_W-1:0] rowIdx;
  always_comb begin
    rowIdx = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (rowSync[i]) rowIdx = ROW_W'(i);
    end
  end

  // shared period / settle timer
  logic [TMR_W-1:0] timer;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               timer <= TMR_W'(IDLE_PERIOD - 1);
    else if (ctrl.loadIdle)   timer <= TMR_W'(IDLE_PERIOD - 1);
    else if (ctrl.loadSettle) timer <= TMR_W'(SETTLE_CYCLES - 1);
    else if (timer != '0)     timer <= timer - 1'b1;
  end

  // column pointer
  logic [COL_W-1:0] colIdx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               colIdx <= '0;
    else if (ctrl.colReset)   colIdx <= '0;
    else if (ctrl.colAdvance) colIdx <= colIdx + 1'b1;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_strobe
    assign colStrobe[c] = ctrl.driveAll | (colIdx == COL_W'(c));
  end

  // debounce match tracking
  logic [CODE_W-1:0] candidate, lastCode;
  logic [CNT_W-1:0]  matchCnt, nextCnt;
  logic              sameCode, acceptNow;

  assign candidate = {colIdx, rowIdx};
  assign sameCode  = (matchCnt != '0) && (candidate == lastCode);
  assign nextCnt   = sameCode ? matchCnt + 1'b1 : CNT_W'(1);
  assign acceptNow = ctrl.evalCand && (nextCnt == CNT_W'(DEBOUNCE_COUNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matchCnt <= '0;
      lastCode <= '0;
    end else if (ctrl.clearMatch) begin
      matchCnt <= '0;
    end else if (ctrl.evalCand) begin
      lastCode <= candidate;
      matchCnt <= acceptNow ? '0 : nextCnt;
    end
  end

  // release lock
  logic             locked;
  logic [CNT_W-1:0] relCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      relCnt <= '0;
    end else if (acceptNow) begin
      locked <= 1'b1;
      relCnt <= '0;
    end else if (locked && ctrl.sampleZeroIdle) begin
      if (relCnt == CNT_W'(DEBOUNCE_COUNT - 1)) begin
        locked <= 1'b0;
        relCnt <= '0;
      end else begin
        relCnt <= relCnt + 1'b1;
      end
    end else if (ctrl.sampleHitLocked) begin
      relCnt <= '0;
    end
  end

  // host-visible registers
  logic [CODE_W-1:0] codeReg;
  logic              validReg, irqReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeReg  <= '0;
      validReg <= 1'b0;
      irqReg   <= 1'b0;
    end else if (acceptNow) begin
      codeReg  <= candidate;
      validReg <= 1'b1;
      irqReg   <= 1'b1;
    end else if (rdStrobe) begin
      validReg <= 1'b0;
      irqReg   <= 1'b0;
    end
  end

  assign keyCode  = codeReg;
  assign keyValid = validReg;
  assign irq      = irqReg;

  assign st.timerDone = (timer == '0);
  assign st.rowsHit   = |rowSync;
  assign st.lastCol   = (colIdx == COL_W'(NUM_COLS - 1));
  assign st.locked    = locked;

  // assertions
  assert_strobe_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (colStrobe == '1) || ($countones(colStrobe) == 1));

  assert_debounce_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    matchCnt < CNT_W'(DEBOUNCE_COUNT));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !acceptNow) |=> (!validReg && !irqReg));

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acceptNow |=> $stable(codeReg));

  assert_no_report_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !acceptNow);

  assert_accept_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acceptNow |=> (validReg && irqReg && locked));

endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
  import kps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t st,
  output ctrl_t ctrl
);
  scan_state_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    ctrl.driveAll = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (st.timerDone) begin
          if (!st.rowsHit) begin
            ctrl.sampleZeroIdle = 1'b1;
            ctrl.clearMatch     = 1'b1;
            ctrl.loadIdle       = 1'b1;
          end else if (st.locked) begin
            ctrl.sampleHitLocked = 1'b1;
            ctrl.loadIdle        = 1'b1;
          end else begin
            ctrl.colReset   = 1'b1;
            ctrl.loadSettle = 1'b1;
            nextState       = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (st.timerDone) begin
          if (st.rowsHit) begin
            ctrl.evalCand = 1'b1;
            ctrl.loadIdle = 1'b1;
            nextState     = ST_IDLE;
          end else if (st.lastCol) begin
            ctrl.clearMatch = 1'b1;
            ctrl.loadIdle   = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            ctrl.colAdvance = 1'b1;
            ctrl.loadSettle = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // a locked idle sample never starts a decode pass
  assert_locked_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && st.locked) |=> (state == ST_IDLE));

  // an empty pass past the last column returns to idle
  assert_empty_pass_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && st.timerDone && !st.rowsHit && st.lastCol) |=> (state == ST_IDLE));

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int NUM_COLS       = 8,
  parameter int NUM_ROWS       = 8,
  parameter int IDLE_PERIOD    = 16,
  parameter int SETTLE_CYCLES  = 4,
  parameter int DEBOUNCE_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] rowSense,
  input  logic                rdStrobe,
  output logic [NUM_COLS-1:0] colStrobe,
  output logic [$clog2(NUM_COLS)+$clog2(NUM_ROWS)-1:0] keyCode,
  output logic                keyValid,
  output logic                irq
);
  ctrl_t ctrl;
  stat_t st;

  kps_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (st),
    .ctrl  (ctrl)
  );

  kps_datapath #(
    .NUM_COLS       (NUM_COLS),
    .NUM_ROWS       (NUM_ROWS),
    .IDLE_PERIOD    (IDLE_PERIOD),
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .DEBOUNCE_COUNT (DEBOUNCE_COUNT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .rowSense  (rowSense),
    .rdStrobe  (rdStrobe),
    .st        (st),
    .colStrobe (colStrobe),
    .keyCode   (keyCode),
    .keyValid  (keyValid),
    .irq       (irq)
  );

endmodule

// File: tb/keypad_scanner_tb.sv
`timescale 1ns/1ps
module keypad_scanner_tb;
  localparam int IDLE_P = 16;
  localparam int SETTLE = 4;
  localparam int DEB    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rowSense;
  logic       rdStrobe = 1'b0;
  logic [7:0] colStrobe;
  logic [5:0] keyCode;
  logic       keyValid, irq;

  logic       keyDown = 1'b0;
  logic [2:0] keyCol = '0;
  logic [7:0] keyRows = '0;
  logic       ghost = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  keypad_scanner #(
    .IDLE_PERIOD(IDLE_P), .SETTLE_CYCLES(SETTLE), .DEBOUNCE_COUNT(DEB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rowSense(rowSense), .rdStrobe(rdStrobe),
    .colStrobe(colStrobe), .keyCode(keyCode), .keyValid(keyValid), .irq(irq)
  );

  // matrix model with ideal column isolation
  always_comb begin
    rowSense = '0;
    if (ghost && colStrobe == 8'hFF) rowSense = 8'h01;
    else if (keyDown && colStrobe[keyCol]) rowSense = keyRows;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitValid(input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (keyValid) begin got = 1'b1; break; end
    end
  endtask

  task automatic hostRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic releaseKey();
    keyDown = 1'b0;
    tick((DEB + 3) * IDLE_P);
  endtask

  task automatic press(input logic [2:0] c, input logic [7:0] rows);
    keyCol = c; keyRows = rows; keyDown = 1'b1;
  endtask

  task automatic testReset();
    tick(2);
    check(colStrobe == 8'hFF, "R1", "colStrobe after reset", colStrobe, 8'hFF);
    check(!keyValid, "R1", "keyValid after reset", keyValid, 0);
    check(!irq, "R1", "irq after reset", irq, 0);
    check(keyCode == 6'h00, "R1", "keyCode after reset", keyCode, 0);
  endtask

  task automatic testIdle();
    int bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (colStrobe != 8'hFF) bad++;
    end
    check(bad == 0, "R2", "non-FF idle strobe cycles", bad, 0);
  endtask

  // column 3, row 5: pass walks 0..3, then code, read, hold, re-press
  task automatic testScanAndReport();
    bit got;
    int cnt;
    press(3'd3, 8'h20);
    for (int i = 0; i < 200 && colStrobe == 8'hFF; i++) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      cnt = 0;
      while (colStrobe == (8'h01 << c) && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == SETTLE, "R10", $sformatf("column %0d drive length", c), cnt, SETTLE);
    end
    check(colStrobe == 8'hFF, "R3", "strobes after hit column", colStrobe, 8'hFF);
    waitValid(3000, got);
    check(got && keyCode == 6'h1D, "R4", "code col3 row5", keyCode, 6'h1D);
    check(irq, "R6", "irq on accept", irq, 1);
    hostRead();
    check(!keyValid && !irq, "R7", "valid|irq after read", {keyValid, irq}, 0);
    check(keyCode == 6'h1D, "R7", "code kept after read", keyCode, 6'h1D);
    tick(400);
    check(!keyValid, "R8", "held key reported again", keyValid, 0);
    releaseKey();
    press(3'd3, 8'h20);
    waitValid(3000, got);
    check(got, "R8", "new press after release reported", got, 1);
    hostRead();
    releaseKey();
  endtask

  task automatic testLowestRow();
    bit got;
    press(3'd6, 8'hA4);
    waitValid(3000, got);
    check(got && keyCode == 6'h32, "R4", "lowest row col6 rows A4", keyCode, 6'h32);
    hostRead();
    releaseKey();
  endtask

  // count decode passes before acceptance
  task automatic testDebounceCount();
    int scans = 0;
    logic [7:0] prev = 8'hFF;
    press(3'd7, 8'h80);
    for (int i = 0; i < 3000 && !keyValid; i++) begin
      @(negedge clk);
      if (prev == 8'hFF && colStrobe == 8'h01) scans++;
      prev = colStrobe;
    end
    check(scans == DEB, "R5", "passes before accept", scans, DEB);
    check(keyValid && keyCode == 6'h3F, "R6", "code col7 row7", keyCode, 6'h3F);
    hostRead();
    releaseKey();
  endtask

  task automatic testZeroCode();
    bit got;
    press(3'd0, 8'h01);
    waitValid(3000, got);
    check(got && keyCode == 6'h00, "R4", "code col0 row0", keyCode, 0);
    hostRead();
    releaseKey();
  endtask

  task automatic testShortPress();
    press(3'd2, 8'h08);
    tick(40);
    keyDown = 1'b0;
    tick(400);
    check(!keyValid, "R5", "short press reported", keyValid, 0);
  endtask

  task automatic testGhost();
    bit sawLast = 1'b0;
    ghost = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (colStrobe == 8'h80) sawLast = 1'b1;
    end
    ghost = 1'b0;
    check(sawLast, "R9", "empty pass reached column 7", sawLast, 1);
    tick(60);
    check(!keyValid && colStrobe == 8'hFF, "R9", "empty pass result",
          {keyValid, colStrobe}, 8'hFF);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    testReset();
    testIdle();
    testScanAndReport();
    testLowestRow();
    testDebounceCount();
    testZeroCode();
    testShortPress();
    testGhost();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule